// File: doc/BRIEF.md
# Audio Port Signal Routing Crossbar

This block links six serial audio ports. Each port owns a 32-bit configuration word, written and read over a simple register bus that uses one address per port. The word sets whether the port drives its transmit frame sync, transmit clock, receive frame sync and receive clock pins. It also picks which other port supplies each driven signal, and which port supplies the port's receive data.

All routing from pad inputs to pad outputs is combinational. Only the configuration words are held in flip-flops. Each routed signal comes out as an output-enable and a value. When a signal is not driven, its enable is low and its value is 0. A port can run in synchronous (4-wire) mode. In that mode its receive side uses the transmit clock and frame sync, and its own receive clock and frame sync pins are never driven.

Top module: `audx_crossbar`

## Requirements
- R1: After a synchronous active-high reset, every port's configuration word reads 0x0000_1000. Only the synchronous-mode bit (bit 12) is set.
- R2: A write with `wr_en` high to an address from 0 to 5 loads that port's word, with bits 19:16 and 11:0 forced to zero. Reading an address from 0 to 5 returns that port's word. Addresses 6 and 7 ignore writes and read as zero.
- R3: Bit 31 high makes the port drive TxFS from the source chosen by bits 29:26. Bit 31 low leaves TxFS undriven (oe 0, value 0), whatever bits 29:26 hold.
- R4: Bit 30 controls TxClk in the same way, using the same source field, bits 29:26.
- R5: In a 4-bit source field, the top bit picks the source port's transmit set (0) or receive set (1). The lower 3 bits give the source port, where code k selects port index k (codes 0 to 5). The value routed is the source pad's input level.
- R6: A source code equal to the port's own index, or a reserved code (6 or 7), leaves the signal undriven (oe 0, value 0).
- R7: In asynchronous mode (bit 12 low), bit 25 controls RxFS and bit 24 controls RxClk. Both take their source from bits 23:20, under the R5 and R6 rules.
- R8: In synchronous mode (bit 12 high), the port's RxFS and RxClk are undriven. Another port that selects this port's receive set gets this port's TxFS and TxClk input levels instead.
- R9: Bits 15:13 name the port whose transmit data input drives this port's receive data, with `rxd_oe` high. A self or reserved code gives `rxd_oe` 0 and `rxd_out` 0.
- R10: Routed outputs follow pad inputs within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Port index written |
| wr_data | input | 32 | Configuration word written |
| rd_addr | input | 3 | Port index read |
| rd_data | output | 32 | Configuration word read (combinational) |
| txfs_in | input | 6 | TxFS pad input level per port |
| txclk_in | input | 6 | TxClk pad input level per port |
| rxfs_in | input | 6 | RxFS pad input level per port |
| rxclk_in | input | 6 | RxClk pad input level per port |
| txd_in | input | 6 | Transmit data input per port |
| txfs_oe | output | 6 | TxFS output enable per port |
| txfs_out | output | 6 | TxFS output value per port |
| txclk_oe | output | 6 | TxClk output enable per port |
| txclk_out | output | 6 | TxClk output value per port |
| rxfs_oe | output | 6 | RxFS output enable per port |
| rxfs_out | output | 6 | RxFS output value per port |
| rxclk_oe | output | 6 | RxClk output enable per port |
| rxclk_out | output | 6 | RxClk output value per port |
| rxd_oe | output | 6 | Receive data output enable per port |
| rxd_out | output | 6 | Receive data output value per port |

## Verification
The bench targets several corner cases:
- Self-selection and the reserved codes 6 and 7. A design that only checks the code range would drive a port from its own pad.
- Selecting the receive set of a source that is in synchronous mode. A design that ignores the source's mode would pass through a receive pin that nothing uses.
- A port in synchronous mode with its receive direction bits still set. A faulty design would keep driving RxFS and RxClk.
- Writes of all ones and writes to the unused addresses. A design that stores reserved bits, or decodes the address loosely, would read back the wrong word or corrupt a port's register.

// File: rtl/audx_pkg.sv
package audx_pkg;

    localparam int unsigned CODE_W = 3;
    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] CFG_WMASK = 32'hFFF0_F000;
    localparam logic [WORD_W-1:0] CFG_RESET = 32'h0000_1000;

    typedef enum logic {
        SET_TX = 1'b0,
        SET_RX = 1'b1
    } sigset_e;

    typedef struct packed {
        sigset_e             set;
        logic [CODE_W-1:0]   port;
    } src_sel_t;

    // Field order follows the bit positions of the configuration word.
    typedef struct packed {
        logic                tx_fs_drive;   // 31
        logic                tx_clk_drive;  // 30
        src_sel_t            tx_src;        // 29:26
        logic                rx_fs_drive;   // 25
        logic                rx_clk_drive;  // 24
        src_sel_t            rx_src;        // 23:20
        logic [3:0]          rsvd_hi;       // 19:16
        logic [CODE_W-1:0]   data_port;     // 15:13
        logic                sync_mode;     // 12
        logic [11:0]         rsvd_lo;       // 11:0
    } cfg_t;

    typedef struct packed {
        logic oe;
        logic val;
    } drive_t;

    function automatic logic sel_usable(logic [CODE_W-1:0] code, int self_idx, int nports);
        return (int'(code) < nports) && (int'(code) != self_idx);
    endfunction

endpackage

// File: rtl/audx_cfg_regs.sv
module audx_cfg_regs
    import audx_pkg::*;
#(
    parameter int NPORTS = 6,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [WORD_W-1:0]        rd_data,
    output cfg_t [NPORTS-1:0]        cfg_q
);

    for (genvar p = 0; p < NPORTS; p++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[p] <= cfg_t'(CFG_RESET);
            end else if (wr_en && (int'(wr_addr) == p)) begin
                cfg_q[p] <= cfg_t'(wr_data & CFG_WMASK);
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (int'(rd_addr) == p) begin
                rd_data = cfg_q[p];
            end
        end
    end

endmodule

// File: rtl/audx_route_port.sv
module audx_route_port
    import audx_pkg::*;
#(
    parameter int NPORTS = 6,
    parameter int SELF   = 0
) (
    input  cfg_t              cfg,
    input  logic [NPORTS-1:0] txfs_in,
    input  logic [NPORTS-1:0] txclk_in,
    input  logic [NPORTS-1:0] eff_rxfs,
    input  logic [NPORTS-1:0] eff_rxclk,
    input  logic [NPORTS-1:0] txd_in,
    output drive_t            txfs_d,
    output drive_t            txclk_d,
    output drive_t            rxfs_d,
    output drive_t            rxclk_d,
    output drive_t            rxd_d
);

    logic unused_rsvd;
    assign unused_rsvd = ^{cfg.rsvd_hi, cfg.rsvd_lo};

    function automatic drive_t route(logic en, src_sel_t s,
                                     logic [NPORTS-1:0] tx_v,
                                     logic [NPORTS-1:0] rx_v);
        drive_t d;
        d = '0;
        if (en && sel_usable(s.port, SELF, NPORTS)) begin
            d.oe  = 1'b1;
            d.val = (s.set == SET_RX) ? rx_v[s.port] : tx_v[s.port];
        end
        return d;
    endfunction

    logic     rx_async;
    src_sel_t data_sel;

    always_comb begin
        rx_async = !cfg.sync_mode;
        data_sel = '{set: SET_TX, port: cfg.data_port};
        txfs_d   = route(cfg.tx_fs_drive,              cfg.tx_src, txfs_in,  eff_rxfs);
        txclk_d  = route(cfg.tx_clk_drive,             cfg.tx_src, txclk_in, eff_rxclk);
        rxfs_d   = route(cfg.rx_fs_drive  && rx_async, cfg.rx_src, txfs_in,  eff_rxfs);
        rxclk_d  = route(cfg.rx_clk_drive && rx_async, cfg.rx_src, txclk_in, eff_rxclk);
        rxd_d    = route(1'b1, data_sel, txd_in, txd_in);
    end

endmodule

// File: rtl/audx_crossbar.sv
module audx_crossbar
    import audx_pkg::*;
#(
    parameter int NPORTS = 6,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [NPORTS-1:0] txfs_in,
    input  logic [NPORTS-1:0] txclk_in,
    input  logic [NPORTS-1:0] rxfs_in,
    input  logic [NPORTS-1:0] rxclk_in,
    input  logic [NPORTS-1:0] txd_in,
    output logic [NPORTS-1:0] txfs_oe,
    output logic [NPORTS-1:0] txfs_out,
    output logic [NPORTS-1:0] txclk_oe,
    output logic [NPORTS-1:0] txclk_out,
    output logic [NPORTS-1:0] rxfs_oe,
    output logic [NPORTS-1:0] rxfs_out,
    output logic [NPORTS-1:0] rxclk_oe,
    output logic [NPORTS-1:0] rxclk_out,
    output logic [NPORTS-1:0] rxd_oe,
    output logic [NPORTS-1:0] rxd_out
);

    cfg_t [NPORTS-1:0] cfg_q;
    logic [NPORTS-1:0] eff_rxfs;
    logic [NPORTS-1:0] eff_rxclk;

    audx_cfg_regs #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg_q   (cfg_q)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        drive_t d_txfs, d_txclk, d_rxfs, d_rxclk, d_rxd;

        // A 4-wire port presents its transmit timing as its receive set.
        assign eff_rxfs[p]  = cfg_q[p].sync_mode ? txfs_in[p]  : rxfs_in[p];
        assign eff_rxclk[p] = cfg_q[p].sync_mode ? txclk_in[p] : rxclk_in[p];

        audx_route_port #(.NPORTS(NPORTS), .SELF(p)) u_route (
            .cfg       (cfg_q[p]),
            .txfs_in   (txfs_in),
            .txclk_in  (txclk_in),
            .eff_rxfs  (eff_rxfs),
            .eff_rxclk (eff_rxclk),
            .txd_in    (txd_in),
            .txfs_d    (d_txfs),
            .txclk_d   (d_txclk),
            .rxfs_d    (d_rxfs),
            .rxclk_d   (d_rxclk),
            .rxd_d     (d_rxd)
        );

        assign txfs_oe[p]   = d_txfs.oe;
        assign txfs_out[p]  = d_txfs.val;
        assign txclk_oe[p]  = d_txclk.oe;
        assign txclk_out[p] = d_txclk.val;
        assign rxfs_oe[p]   = d_rxfs.oe;
        assign rxfs_out[p]  = d_rxfs.val;
        assign rxclk_oe[p]  = d_rxclk.oe;
        assign rxclk_out[p] = d_rxclk.val;
        assign rxd_oe[p]    = d_rxd.oe;
        assign rxd_out[p]   = d_rxd.val;
    end

endmodule

// File: rtl/audx_crossbar_chk.sv
module audx_crossbar_chk
    import audx_pkg::*;
#(
    parameter int NPORTS = 6,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data,
    input cfg_t [NPORTS-1:0] cfg_q,
    input logic [NPORTS-1:0] txfs_oe,
    input logic [NPORTS-1:0] txfs_out,
    input logic [NPORTS-1:0] txclk_oe,
    input logic [NPORTS-1:0] txclk_out,
    input logic [NPORTS-1:0] rxfs_oe,
    input logic [NPORTS-1:0] rxfs_out,
    input logic [NPORTS-1:0] rxclk_oe,
    input logic [NPORTS-1:0] rxclk_out,
    input logic [NPORTS-1:0] rxd_oe,
    input logic [NPORTS-1:0] rxd_out
);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~CFG_WMASK) == 32'h0);

    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        assert_reset_word_R1: assert property (@(posedge clk)
            rst |=> (cfg_q[p] == cfg_t'(CFG_RESET)));

        assert_write_load_R2: assert property (@(posedge clk) disable iff (rst)
            (wr_en && int'(wr_addr) == p) |=> (cfg_q[p] == cfg_t'($past(wr_data) & CFG_WMASK)));

        assert_txfs_input_R3: assert property (@(posedge clk) disable iff (rst)
            !cfg_q[p].tx_fs_drive |-> !txfs_oe[p]);

        assert_txclk_input_R4: assert property (@(posedge clk) disable iff (rst)
            !cfg_q[p].tx_clk_drive |-> !txclk_oe[p]);

        assert_idle_low_R6: assert property (@(posedge clk) disable iff (rst)
            ({txfs_out[p] & !txfs_oe[p], txclk_out[p] & !txclk_oe[p],
              rxfs_out[p] & !rxfs_oe[p], rxclk_out[p] & !rxclk_oe[p],
              rxd_out[p] & !rxd_oe[p]}) == 5'b0);

        assert_tx_self_R6: assert property (@(posedge clk) disable iff (rst)
            (txfs_oe[p] || txclk_oe[p]) |-> (int'(cfg_q[p].tx_src.port) != p));

        assert_sync_rx_idle_R8: assert property (@(posedge clk) disable iff (rst)
            cfg_q[p].sync_mode |-> (!rxfs_oe[p] && !rxclk_oe[p]));

        assert_rxd_valid_R9: assert property (@(posedge clk) disable iff (rst)
            rxd_oe[p] |-> (int'(cfg_q[p].data_port) != p && int'(cfg_q[p].data_port) < NPORTS));
    end

endmodule

bind audx_crossbar audx_crossbar_chk #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .cfg_q     (cfg_q),
    .txfs_oe   (txfs_oe),
    .txfs_out  (txfs_out),
    .txclk_oe  (txclk_oe),
    .txclk_out (txclk_out),
    .rxfs_oe   (rxfs_oe),
    .rxfs_out  (rxfs_out),
    .rxclk_oe  (rxclk_oe),
    .rxclk_out (rxclk_out),
    .rxd_oe    (rxd_oe),
    .rxd_out   (rxd_out)
);

// File: tb/test_audx_crossbar.sv
module test_audx_crossbar;

    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [N-1:0] txfs_in = '0, txclk_in = '0, rxfs_in = '0, rxclk_in = '0, txd_in = '0;
    logic [N-1:0] txfs_oe, txfs_out, txclk_oe, txclk_out;
    logic [N-1:0] rxfs_oe, rxfs_out, rxclk_oe, rxclk_out, rxd_oe, rxd_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] mdl [N];

    always #2.5 clk = ~clk;

    audx_crossbar i_audx_crossbar (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .txfs_in(txfs_in), .txclk_in(txclk_in), .rxfs_in(rxfs_in), .rxclk_in(rxclk_in),
        .txd_in(txd_in),
        .txfs_oe(txfs_oe), .txfs_out(txfs_out), .txclk_oe(txclk_oe), .txclk_out(txclk_out),
        .rxfs_oe(rxfs_oe), .rxfs_out(rxfs_out), .rxclk_oe(rxclk_oe), .rxclk_out(rxclk_out),
        .rxd_oe(rxd_oe), .rxd_out(rxd_out)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // kind: 0 TxFS, 1 TxClk, 2 RxFS, 3 RxClk, 4 RxD; result {oe, value}
    function automatic logic [1:0] expect_drive(int p, int kind);
        logic [31:0] m = mdl[p];
        logic        dir;
        logic [3:0]  code;
        int          k;
        logic        v;
        case (kind)
            0: begin dir = m[31]; code = m[29:26]; end
            1: begin dir = m[30]; code = m[29:26]; end
            2: begin dir = m[25] && !m[12]; code = m[23:20]; end
            3: begin dir = m[24] && !m[12]; code = m[23:20]; end
            default: begin dir = 1'b1; code = {1'b0, m[15:13]}; end
        endcase
        k = int'(code[2:0]);
        if (!dir || k >= N || k == p) return 2'b00;
        if (kind == 4) v = txd_in[k];
        else if (!code[3] || mdl[k][12]) v = (kind == 0 || kind == 2) ? txfs_in[k] : txclk_in[k];
        else v = (kind == 0 || kind == 2) ? rxfs_in[k] : rxclk_in[k];
        return {1'b1, v};
    endfunction

    task automatic check_outputs(string ctx);
        for (int p = 0; p < N; p++) begin
            string rxtag = mdl[p][12] ? "R8" : "R7";
            check("R3", $sformatf("%s txfs p%0d", ctx, p), {txfs_oe[p], txfs_out[p]}, expect_drive(p, 0));
            check("R4", $sformatf("%s txclk p%0d", ctx, p), {txclk_oe[p], txclk_out[p]}, expect_drive(p, 1));
            check(rxtag, $sformatf("%s rxfs p%0d", ctx, p), {rxfs_oe[p], rxfs_out[p]}, expect_drive(p, 2));
            check(rxtag, $sformatf("%s rxclk p%0d", ctx, p), {rxclk_oe[p], rxclk_out[p]}, expect_drive(p, 3));
            check("R9", $sformatf("%s rxd p%0d", ctx, p), {rxd_oe[p], rxd_out[p]}, expect_drive(p, 4));
        end
    endtask

    task automatic write_reg(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < N) mdl[a] = d & 32'hFFF0_F000;
    endtask

    task automatic read_check(string tag, int a);
        rd_addr = 3'(a);
        #1;
        check(tag, $sformatf("readback addr %0d", a), rd_data, (a < N) ? mdl[a] : 32'h0);
    endtask

    initial begin
        void'($urandom(32'd1357));
        for (int p = 0; p < N; p++) mdl[p] = 32'h0000_1000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset word on every port, unused addresses read zero
        for (int a = 0; a < 8; a++) read_check("R1", a);
        check_outputs("reset");

        // R2: reserved bits masked, writes to unused addresses ignored
        write_reg(2, 32'hFFFF_FFFF);
        read_check("R2", 2);
        write_reg(7, 32'hFFFF_FFFF);
        write_reg(6, 32'hA5A5_A5A5);
        for (int a = 0; a < 8; a++) read_check("R2", a);

        // R5: port 0 drives TxFS/TxClk from port 3 receive set, port 3 asynchronous
        write_reg(3, 32'h0000_0000);
        write_reg(0, 32'hC000_0000 | (32'h8 + 32'h3) << 26);
        txfs_in = 6'b000000; rxfs_in = 6'b001000; txclk_in = 6'b001000; rxclk_in = 6'b000000;
        #1;
        check("R5", "rx set of async port3 fs", {txfs_oe[0], txfs_out[0]}, 2'b11);
        check("R5", "rx set of async port3 clk", {txclk_oe[0], txclk_out[0]}, 2'b10);
        // R8: port 3 switched to synchronous mode hands out its transmit pins
        write_reg(3, 32'h0300_1000);
        #1;
        check("R8", "sync port3 fs as rx set", {txfs_oe[0], txfs_out[0]}, 2'b10);
        check("R8", "sync port3 clk as rx set", {txclk_oe[0], txclk_out[0]}, 2'b11);
        check("R8", "sync port3 rx pins idle", {rxfs_oe[3], rxclk_oe[3]}, 2'b00);
        // R10: input change with no clock edge in between
        @(posedge clk); #1;
        txfs_in = 6'b001000;
        #0.5;
        check("R10", "txfs follows pad mid-cycle", {txfs_oe[0], txfs_out[0]}, 2'b11);

        // R6: self code and reserved codes
        txfs_in = 6'b111111; txclk_in = 6'b111111;
        write_reg(1, 32'hC000_0000 | 32'h1 << 26);
        #1;
        check("R6", "self select txfs", {txfs_oe[1], txfs_out[1]}, 2'b00);
        write_reg(1, 32'hC000_0000 | 32'h6 << 26);
        #1;
        check("R6", "reserved code 6", {txfs_oe[1], txfs_out[1]}, 2'b00);
        write_reg(1, 32'hC000_0000 | 32'hF << 26);
        #1;
        check("R6", "reserved code 7", {txclk_oe[1], txclk_out[1]}, 2'b00);
        // R3: input direction ignores a valid select
        write_reg(1, 32'h0000_0000 | 32'h2 << 26);
        #1;
        check("R3", "input dir ignores select", {txfs_oe[1], txfs_out[1]}, 2'b00);
        // R9: receive data select, self and valid
        txd_in = 6'b010000;
        write_reg(1, 32'h4 << 13);
        #1;
        check("R9", "rxd from port4", {rxd_oe[1], rxd_out[1]}, 2'b11);
        write_reg(4, 32'h4 << 13);
        #1;
        check("R9", "rxd self select", {rxd_oe[4], rxd_out[4]}, 2'b00);
        check_outputs("directed");

        // Constrained random: direction bits and valid codes favoured
        for (int it = 0; it < 400; it++) begin
            logic [31:0] d = $urandom;
            if ($urandom_range(3) != 0) d[28:26] = 3'($urandom_range(5));
            if ($urandom_range(3) != 0) d[22:20] = 3'($urandom_range(5));
            if ($urandom_range(3) != 0) d[15:13] = 3'($urandom_range(5));
            if ($urandom_range(7) == 0) write_reg($urandom_range(7), d);
            else write_reg($urandom_range(N - 1), d);
            txfs_in = 6'($urandom); txclk_in = 6'($urandom); rxfs_in = 6'($urandom);
            rxclk_in = 6'($urandom); txd_in = 6'($urandom);
            #1;
            check_outputs("random");
            read_check("R2", $urandom_range(7));
            // R10: pads move between edges, outputs follow at once
            txfs_in = 6'($urandom); rxclk_in = 6'($urandom); txd_in = 6'($urandom);
            #0.5;
            check_outputs("R10 mid-cycle");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule